// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block sits between a configuration port and the fuse pattern that sets up a chip's programmable logic. A host issues commands over a synchronous command, address and data port. The commands can program fuse words, read fuse words back, force a value into the logic's state registers, read or write a 64-bit user signature, lock the device, and run a full wipe. The fuse pattern is held in ordinary registers and is driven out in parallel on `cfg_fuses` for the logic that uses it.

A one-time lock bit, once written, stops readback and state preload at once. A command accepted on the next cycle is already refused. The user signature is eight bytes and can still be read and written while locked. Only the wipe command clears the lock. A wipe runs over several cycles and also clears every fuse word and the whole signature.

Every command is taken in a cycle where both `cmd_valid` and `cmd_ready` are high. Its response is a one-cycle `rsp_valid` pulse in the cycle that follows.

Top module: `cfg_access_ctrl`

## Requirements
- R1: A command is accepted in a cycle where cmd_valid and cmd_ready are both high. rsp_valid is high for exactly the one cycle that follows each accepted command and is low at all other times. cmd_ready is high whenever no wipe is running.
- R2: Program (cmd_op 0) ORs cmd_wdata into the fuse word at cmd_addr, so a fuse bit never returns to 0 except by wipe. The word appears at bits [addr*DATA_W +: DATA_W] of cfg_fuses from the response cycle on. Program is allowed whether or not the device is locked.
- R3: Readback (cmd_op 1) on an unlocked device returns the addressed fuse word on rsp_data with rsp_err low.
- R4: Lock (cmd_op 5) sets `secured` in the response cycle. A readback accepted in any later cycle, including the very next one, returns rsp_data all zeros with rsp_err high.
- R5: Preload (cmd_op 2) on an unlocked device pulses pl_valid for one cycle, in the response cycle, with pl_data equal to cmd_wdata[PRELOAD_W-1:0]. On a locked device it raises rsp_err and pl_valid stays low.
- R6: Signature write (cmd_op 3) stores cmd_wdata[7:0] at byte address cmd_addr (0 to 7). Signature read (cmd_op 4) returns that byte, zero-extended, on rsp_data. Both work with rsp_err low whether or not the device is locked.
- R7: A signature command with cmd_addr of 8 or more raises rsp_err and changes no signature byte.
- R8: Wipe (cmd_op 6) drops cmd_ready for exactly FUSE_WORDS cycles after its acceptance cycle. When cmd_ready returns, every fuse word, every signature byte and `secured` are zero. A wipe is the only command that lowers `secured`.
- R9: The reserved code (cmd_op 7) raises rsp_err and leaves the fuses, the signature and the lock unchanged.
- R10: While and after reset, and until the first command, cmd_ready is 1 and rsp_valid, pl_valid, secured and all of cfg_fuses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Fuse word or signature byte address |
| cmd_wdata | input | DATA_W | Program, preload or signature data |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_err | output | 1 | Command refused or malformed |
| rsp_data | output | DATA_W | Read data, zero when not a successful read |
| pl_valid | output | 1 | Preload strobe to the state registers |
| pl_data | output | PRELOAD_W | Value to force into the state registers |
| secured | output | 1 | Lock bit |
| cfg_fuses | output | FUSE_WORDS*DATA_W | Full fuse pattern, word 0 in the low bits |

## Verification
Directed sequences come first. Two overlapping programs to one word are read back, which separates an OR-in from an overwrite. A lock is followed in the very next cycle by a readback and a preload, which shows whether the lock is immediate or lags a cycle. Out-of-range signature writes are followed by reads of the byte that a truncated address would hit, which exposes address aliasing. The length of a wipe is counted cycle by cycle, and its aftermath is read back through the normal port. After that, a long pseudo-random stream of back-to-back and spaced commands is run against a behavioural model on every cycle. This stream includes locks and wipes at random points, so the lock's interaction with every other command gets covered.

// File: rtl/cfgac_pkg.sv
package cfgac_pkg;

  typedef enum logic [2:0] {
    OP_BURN     = 3'd0,
    OP_READBACK = 3'd1,
    OP_PRELOAD  = 3'd2,
    OP_SIG_WR   = 3'd3,
    OP_SIG_RD   = 3'd4,
    OP_LOCK     = 3'd5,
    OP_WIPE     = 3'd6,
    OP_RSVD     = 3'd7
  } cfg_op_e;

endpackage

// File: rtl/cfgac_fuse_bank.sv
// Fuse word storage: bits are only ever set by a burn and cleared by a wipe.
module cfgac_fuse_bank #(
  parameter int WORDS = 16,
  parameter int WIDTH = 16,
  parameter int AW    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   burn_en,
  input  logic [AW-1:0]          burn_addr,
  input  logic [WIDTH-1:0]       burn_data,
  input  logic                   wipe_en,
  input  logic [AW-1:0]          wipe_addr,
  input  logic [AW-1:0]          rd_addr,
  output logic [WIDTH-1:0]       rd_data,
  output logic [WORDS*WIDTH-1:0] fuse_flat
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] word_d;
    logic             word_en;

    always_comb begin
      word_en = 1'b0;
      word_d  = word_q;
      if (wipe_en && (wipe_addr == AW'(w))) begin
        word_en = 1'b1;
        word_d  = '0;
      end else if (burn_en && (burn_addr == AW'(w))) begin
        word_en = 1'b1;
        word_d  = word_q | burn_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign fuse_flat[w*WIDTH +: WIDTH] = word_q;
  end

  assign rd_data = fuse_flat[rd_addr*WIDTH +: WIDTH];

endmodule

// File: rtl/cfgac_sig_bank.sv
// Byte-wide user signature storage, cleared as a whole by a wipe.
module cfgac_sig_bank #(
  parameter int BYTES = 8,
  parameter int BAW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [BAW-1:0] wr_addr,
  input  logic [7:0]     wr_data,
  input  logic           clr,
  input  logic [BAW-1:0] rd_addr,
  output logic [7:0]     rd_data
);

  logic [BYTES*8-1:0] sig_flat;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    logic [7:0] byte_d;
    logic       byte_en;

    always_comb begin
      byte_en = 1'b0;
      byte_d  = byte_q;
      if (clr) begin
        byte_en = 1'b1;
        byte_d  = '0;
      end else if (wr_en && (wr_addr == BAW'(b))) begin
        byte_en = 1'b1;
        byte_d  = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= byte_d;
      end
    end

    assign sig_flat[b*8 +: 8] = byte_q;
  end

  assign rd_data = sig_flat[rd_addr*8 +: 8];

endmodule

// File: rtl/cfgac_ctrl.sv
// Command decode, lock bit, wipe sequencing and registered responses.
module cfgac_ctrl
  import cfgac_pkg::*;
#(
  parameter int FUSE_WORDS = 16,
  parameter int DATA_W     = 16,
  parameter int SIG_BYTES  = 8,
  parameter int PRELOAD_W  = 10,
  parameter int ADDR_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [DATA_W-1:0]    cmd_wdata,
  output logic                 cmd_ready,
  input  logic [DATA_W-1:0]    fuse_rd_data,
  input  logic [7:0]           sig_rd_data,
  output logic                 burn_en,
  output logic                 wipe_en,
  output logic [ADDR_W-1:0]    wipe_addr,
  output logic                 sig_wr_en,
  output logic                 sig_clr,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [DATA_W-1:0]    rsp_data,
  output logic                 pl_valid,
  output logic [PRELOAD_W-1:0] pl_data,
  output logic                 secured
);

  localparam logic [ADDR_W:0]   SIG_LIM  = (ADDR_W+1)'(SIG_BYTES);
  localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(FUSE_WORDS - 1);

  cfg_op_e op;
  logic    accept;
  logic    sig_ok;
  logic    state_en;

  logic                 secured_q, secured_d;
  logic                 busy_q, busy_d;
  logic [ADDR_W-1:0]    idx_q, idx_d;
  logic                 rsp_valid_d, rsp_err_d;
  logic [DATA_W-1:0]    rsp_data_d;
  logic                 pl_valid_d;
  logic [PRELOAD_W-1:0] pl_data_d;

  assign op        = cfg_op_e'(cmd_op);
  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && !busy_q;
  assign sig_ok    = ({1'b0, cmd_addr} < SIG_LIM);
  assign state_en  = busy_q || accept;
  assign wipe_addr = idx_q;

  always_comb begin
    secured_d   = secured_q;
    busy_d      = busy_q;
    idx_d       = idx_q;
    rsp_valid_d = accept;
    rsp_err_d   = 1'b0;
    rsp_data_d  = '0;
    pl_valid_d  = 1'b0;
    pl_data_d   = '0;
    burn_en     = 1'b0;
    wipe_en     = 1'b0;
    sig_wr_en   = 1'b0;
    sig_clr     = 1'b0;
    if (busy_q) begin
      wipe_en = 1'b1;
      idx_d   = idx_q + 1'b1;
      if (idx_q == IDX_LAST) begin
        busy_d    = 1'b0;
        secured_d = 1'b0;
        sig_clr   = 1'b1;
      end
    end else if (accept) begin
      unique case (op)
        OP_BURN:     burn_en = 1'b1;
        OP_READBACK: begin
          if (secured_q) rsp_err_d  = 1'b1;
          else           rsp_data_d = fuse_rd_data;
        end
        OP_PRELOAD: begin
          if (secured_q) begin
            rsp_err_d = 1'b1;
          end else begin
            pl_valid_d = 1'b1;
            pl_data_d  = cmd_wdata[PRELOAD_W-1:0];
          end
        end
        OP_SIG_WR: begin
          if (sig_ok) sig_wr_en = 1'b1;
          else        rsp_err_d = 1'b1;
        end
        OP_SIG_RD: begin
          if (sig_ok) rsp_data_d = DATA_W'(sig_rd_data);
          else        rsp_err_d  = 1'b1;
        end
        OP_LOCK:     secured_d = 1'b1;
        OP_WIPE: begin
          busy_d = 1'b1;
          idx_d  = '0;
        end
        default:     rsp_err_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secured_q <= 1'b0;
      busy_q    <= 1'b0;
      idx_q     <= '0;
    end else if (state_en) begin
      secured_q <= secured_d;
      busy_q    <= busy_d;
      idx_q     <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      pl_valid  <= 1'b0;
      pl_data   <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_data  <= rsp_data_d;
      pl_valid  <= pl_valid_d;
      pl_data   <= pl_data_d;
    end
  end

  assign secured = secured_q;

endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl #(
  parameter int FUSE_WORDS = 16,
  parameter int DATA_W     = 16,
  parameter int SIG_BYTES  = 8,
  parameter int PRELOAD_W  = 10,
  localparam int ADDR_W    = $clog2(FUSE_WORDS),
  localparam int SIG_AW    = $clog2(SIG_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [2:0]                   cmd_op,
  input  logic [ADDR_W-1:0]            cmd_addr,
  input  logic [DATA_W-1:0]            cmd_wdata,
  output logic                         rsp_valid,
  output logic                         rsp_err,
  output logic [DATA_W-1:0]            rsp_data,
  output logic                         pl_valid,
  output logic [PRELOAD_W-1:0]         pl_data,
  output logic                         secured,
  output logic [FUSE_WORDS*DATA_W-1:0] cfg_fuses
);

  logic              burn_en, wipe_en, sig_wr_en, sig_clr;
  logic [ADDR_W-1:0] wipe_addr;
  logic [DATA_W-1:0] fuse_rd_data;
  logic [7:0]        sig_rd_data;

  cfgac_ctrl #(
    .FUSE_WORDS (FUSE_WORDS),
    .DATA_W     (DATA_W),
    .SIG_BYTES  (SIG_BYTES),
    .PRELOAD_W  (PRELOAD_W),
    .ADDR_W     (ADDR_W)
  ) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr),
    .cmd_wdata    (cmd_wdata),
    .cmd_ready    (cmd_ready),
    .fuse_rd_data (fuse_rd_data),
    .sig_rd_data  (sig_rd_data),
    .burn_en      (burn_en),
    .wipe_en      (wipe_en),
    .wipe_addr    (wipe_addr),
    .sig_wr_en    (sig_wr_en),
    .sig_clr      (sig_clr),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_data     (rsp_data),
    .pl_valid     (pl_valid),
    .pl_data      (pl_data),
    .secured      (secured)
  );

  cfgac_fuse_bank #(
    .WORDS (FUSE_WORDS),
    .WIDTH (DATA_W),
    .AW    (ADDR_W)
  ) i_fuses (
    .clk       (clk),
    .rst_n     (rst_n),
    .burn_en   (burn_en),
    .burn_addr (cmd_addr),
    .burn_data (cmd_wdata),
    .wipe_en   (wipe_en),
    .wipe_addr (wipe_addr),
    .rd_addr   (cmd_addr),
    .rd_data   (fuse_rd_data),
    .fuse_flat (cfg_fuses)
  );

  cfgac_sig_bank #(
    .BYTES (SIG_BYTES),
    .BAW   (SIG_AW)
  ) i_sig (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sig_wr_en),
    .wr_addr (cmd_addr[SIG_AW-1:0]),
    .wr_data (cmd_wdata[7:0]),
    .clr     (sig_clr),
    .rd_addr (cmd_addr[SIG_AW-1:0]),
    .rd_data (sig_rd_data)
  );

endmodule

// File: rtl/cfg_access_ctrl_chk.sv
module cfg_access_ctrl_chk #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int SIG_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_data,
  input logic              pl_valid,
  input logic              secured
);

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_rsp_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_no_stray_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  p_lock_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd5) |=> secured);
  p_locked_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd1 && secured) |=> (rsp_err && rsp_data == '0));
  p_locked_preload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd2 && secured) |=> (rsp_err && !pl_valid));
  p_preload_needs_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !pl_valid);
  p_sig_read_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd4 && ({1'b0, cmd_addr} < (ADDR_W+1)'(SIG_BYTES))) |=> !rsp_err);
  p_wipe_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd6) |=> !cmd_ready);
  p_lock_only_by_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secured) |-> !$past(cmd_ready));
  p_reserved_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd7) |=> rsp_err);

endmodule

bind cfg_access_ctrl cfg_access_ctrl_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .SIG_BYTES (SIG_BYTES)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_addr  (cmd_addr),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .pl_valid  (pl_valid),
  .secured   (secured)
);

// File: tb/test_cfg_access_ctrl.sv
`timescale 1ns/1ps
module test_cfg_access_ctrl;

  localparam int NW = 16;
  localparam int DW = 16;
  localparam int NS = 8;
  localparam int PW = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [2:0]        cmd_op = '0;
  logic [3:0]        cmd_addr = '0;
  logic [DW-1:0]     cmd_wdata = '0;
  logic              rsp_valid, rsp_err, pl_valid, secured;
  logic [DW-1:0]     rsp_data;
  logic [PW-1:0]     pl_data;
  logic [NW*DW-1:0]  cfg_fuses;

  int ncmp = 0;
  int nmis = 0;

  always #2 clk = ~clk;

  cfg_access_ctrl i_cfg_access_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .pl_valid(pl_valid), .pl_data(pl_data), .secured(secured),
    .cfg_fuses(cfg_fuses)
  );

  // Behavioural reference model
  logic [DW-1:0] m_fuse [NW];
  logic [7:0]    m_sig  [NS];
  logic          m_sec, m_rv, m_err, m_plv;
  logic [DW-1:0] m_data;
  logic [PW-1:0] m_pld;
  int            m_cnt;
  string         last_tag = "R10";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_fuse[i]) m_fuse[i] = '0;
      foreach (m_sig[i]) m_sig[i] = '0;
      m_sec = 0; m_rv = 0; m_err = 0; m_plv = 0; m_data = '0; m_pld = '0; m_cnt = 0;
    end else begin
      m_rv = 0; m_err = 0; m_plv = 0; m_data = '0; m_pld = '0;
      if (m_cnt > 0) begin
        m_fuse[NW - m_cnt] = '0;
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          foreach (m_sig[i]) m_sig[i] = '0;
          m_sec = 0;
        end
      end else if (cmd_valid) begin
        m_rv = 1;
        case (cmd_op)
          3'd0: m_fuse[cmd_addr] = m_fuse[cmd_addr] | cmd_wdata;
          3'd1: if (m_sec) m_err = 1; else m_data = m_fuse[cmd_addr];
          3'd2: if (m_sec) m_err = 1; else begin m_plv = 1; m_pld = cmd_wdata[PW-1:0]; end
          3'd3: if (cmd_addr < NS) m_sig[cmd_addr] = cmd_wdata[7:0]; else m_err = 1;
          3'd4: if (cmd_addr < NS) m_data = DW'(m_sig[cmd_addr]); else m_err = 1;
          3'd5: m_sec = 1;
          3'd6: m_cnt = NW;
          default: m_err = 1;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NW*DW-1:0] act, input logic [NW*DW-1:0] exp);
    ncmp++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NW*DW-1:0] flat;
      foreach (m_fuse[i]) flat[i*DW +: DW] = m_fuse[i];
      check(cmd_ready == (m_cnt == 0), "R8", "ready", cmd_ready, (m_cnt == 0));
      check(rsp_valid == m_rv, "R1", "rsp_valid", rsp_valid, m_rv);
      check(rsp_err == m_err, last_tag, "rsp_err", rsp_err, m_err);
      check(rsp_data == m_data, last_tag, "rsp_data", rsp_data, m_data);
      check(pl_valid == m_plv && pl_data == m_pld, "R5", "preload", {pl_valid, pl_data}, {m_plv, m_pld});
      check(secured == m_sec, "R4", "secured", secured, m_sec);
      check(cfg_fuses == flat, "R2", "cfg_fuses", cfg_fuses, flat);
    end
  end

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return "R4";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Called at a falling edge; returns at the falling edge of the response cycle
  task automatic issue(input logic [2:0] op, input logic [3:0] a, input logic [DW-1:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    last_tag = tag_of(op);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    #(4 * 150000);
    nmis++; ncmp++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int stall;
    repeat (3) @(negedge clk);
    check(cmd_ready && !rsp_valid && !pl_valid && !secured && cfg_fuses == '0,
          "R10", "reset state", {cmd_ready, rsp_valid, pl_valid, secured}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready && !rsp_valid && !secured, "R10", "after release",
          {cmd_ready, rsp_valid, secured}, 3'b100);

    // R2/R3: two programs to one word OR together
    issue(3'd0, 4'd3, 16'h00F0);
    issue(3'd0, 4'd3, 16'h0F00);
    issue(3'd1, 4'd3, 16'h0);
    check(rsp_valid && !rsp_err && rsp_data == 16'h0FF0, "R2", "OR program readback", rsp_data, 16'h0FF0);
    issue(3'd1, 4'd5, 16'h0);
    check(rsp_data == 16'h0 && !rsp_err, "R3", "blank word", rsp_data, 0);
    issue(3'd0, 4'd15, 16'h8001);
    issue(3'd1, 4'd15, 16'h0);
    check(rsp_data == 16'h8001, "R3", "last word readback", rsp_data, 16'h8001);

    // R5: preload while unlocked
    issue(3'd2, 4'd0, 16'hF2A5);
    check(pl_valid && pl_data == 10'h2A5 && !rsp_err, "R5", "preload open", pl_data, 10'h2A5);
    @(negedge clk);
    check(!pl_valid, "R5", "preload one cycle", pl_valid, 0);

    // R6/R7: signature
    issue(3'd3, 4'd7, 16'h00A5);
    issue(3'd3, 4'd0, 16'h003C);
    issue(3'd4, 4'd7, 16'h0);
    check(rsp_data == 16'h00A5 && !rsp_err, "R6", "sig byte 7", rsp_data, 16'h00A5);
    issue(3'd3, 4'd8, 16'h00FF);
    check(rsp_err, "R7", "sig addr 8 err", rsp_err, 1);
    issue(3'd4, 4'd0, 16'h0);
    check(rsp_data == 16'h003C, "R7", "no alias to byte 0", rsp_data, 16'h003C);
    issue(3'd4, 4'd9, 16'h0);
    check(rsp_err && rsp_data == 0, "R7", "sig read addr 9 err", rsp_err, 1);

    // R9: reserved code
    issue(3'd7, 4'd3, 16'hFFFF);
    check(rsp_err, "R9", "reserved err", rsp_err, 1);
    issue(3'd1, 4'd3, 16'h0);
    check(rsp_data == 16'h0FF0 && !secured, "R9", "reserved no effect", rsp_data, 16'h0FF0);

    // R4/R5/R6: lock then immediate refused readback and preload
    issue(3'd5, 4'd0, 16'h0);
    check(secured, "R4", "lock now", secured, 1);
    issue(3'd1, 4'd3, 16'h0);
    check(rsp_err && rsp_data == 0, "R4", "locked readback", rsp_data, 0);
    issue(3'd2, 4'd0, 16'h0155);
    check(rsp_err && !pl_valid, "R5", "locked preload", pl_valid, 0);
    issue(3'd4, 4'd7, 16'h0);
    check(!rsp_err && rsp_data == 16'h00A5, "R6", "sig open while locked", rsp_data, 16'h00A5);

    // R8: wipe
    issue(3'd6, 4'd0, 16'h0);
    stall = 0;
    while (!cmd_ready && stall < 100) begin stall++; @(negedge clk); end
    check(stall == NW, "R8", "wipe stall cycles", stall, NW);
    check(!secured && cfg_fuses == '0, "R8", "wiped state", {secured, cfg_fuses}, 0);
    issue(3'd4, 4'd7, 16'h0);
    check(rsp_data == 0 && !rsp_err, "R8", "signature wiped", rsp_data, 0);
    issue(3'd2, 4'd0, 16'h0011);
    check(pl_valid && !rsp_err, "R8", "preload reopened", pl_valid, 1);

    // Pseudo-random stream compared each cycle (R1 back-to-back)
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = lfsr[2:0];
      if (op == 3'd6 && lfsr[9:7] != 0) op = 3'd1;
      if (op == 3'd5 && lfsr[8]) op = 3'd0;
      issue(op, lfsr[6:3], {lfsr[7:0], lfsr[15:8]});
      if (lfsr[11]) @(negedge clk);
    end
    repeat (NW + 2) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end

endmodule